// File: doc/BRIEF.md
# Dual-Port Double-Rate Burst SRAM

This block is a synchronous on-chip memory with two independent data paths, one for reads and one for writes, that share a single address bus. Each location holds a pair of words, and every access moves that pair as a two-word burst. Data moves on both clock edges. A read request and its address are sampled on the rising edge. A write request is sampled on the rising edge, and its address is taken from the shared bus on the following falling edge. The two write data words follow on the next rising and falling edges. Read data comes out through output registers. The first word appears in the high phase of the cycle after the request, and the second word appears in the low phase of that same cycle.

Because the read and write buses are separate, a read and a write can be issued in every cycle with no bus turnaround. Each port has its own select input, which allows several instances to be stacked for depth expansion. A read that hits a location whose write burst has fully arrived but is not yet stored is served from the write pipeline, not from the array.

Top module: `dpb_sram`

## Requirements
- R1: When `rd_sel_i` is high at rising edge n, the pair stored at `addr_i` is driven on `rd_data_o`. The word stored from the rising-edge write beat (bits [WORD_W-1:0] of the pair) is driven during the high phase of cycle n+1. The word stored from the falling-edge write beat is driven during the low phase of cycle n+1.
- R2: When `wr_sel_i` is high at rising edge n, the write address is sampled from `addr_i` at falling edge n. The first data word is sampled from `wr_data_i` at rising edge n+1, and the second data word at falling edge n+1. The pair is committed to the array at rising edge n+2.
- R3: A read and a write may be requested in the same cycle to different addresses, and both complete as in R1 and R2.
- R4: A read requested in cycle n to the address of a write requested in cycle n-1 returns the new write data.
- R5: A read and a write requested in the same cycle to the same address return the contents the location held before that write.
- R6: While `wr_sel_i` is low at a rising edge, no write is started, and the array keeps its contents whatever is on `addr_i` and `wr_data_i`.
- R7: While `rd_sel_i` is low at rising edge n, `rd_data_o` is zero in both phases of cycle n+1.
- R8: While `rst_ni` is low, `rd_data_o` is zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; rising and falling edges both sample |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Shared address: read address on rising edge, write address on falling edge |
| rd_sel_i | input | 1 | Read port select, sampled on rising edge |
| wr_sel_i | input | 1 | Write port select, sampled on rising edge |
| wr_data_i | input | WORD_W | Double-rate write data bus |
| rd_data_o | output | WORD_W | Double-rate read data bus, zero when idle |

## Verification
The assertions assume that every input settles well away from both clock edges. They also assume that the write data beats arrive on the two edges after a write request, and that no location is read before it has been written, so that no unknown array contents reach the outputs. The bench changes the rising-edge inputs in the low phase and the falling-edge inputs in the high phase. It writes every location of a small eight-entry array before it issues the first read. It drives a fixed nonzero pattern on the write data bus whenever no write beat is due, so that any stray capture would show up on a later read.

// File: rtl/dpb_sram_pkg.sv
package dpb_sram_pkg;
  localparam int unsigned DEF_ADDR_W = 6;
  localparam int unsigned DEF_WORD_W = 18;
endpackage

// File: rtl/dpb_wr_capture.sv
module dpb_wr_capture #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 18,
  localparam int unsigned PAIR_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [PAIR_W-1:0] commit_data_o
);
  logic              req_q;
  logic              aval_n;
  logic [ADDR_W-1:0] addr_n;
  logic              pend_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [WORD_W-1:0] d0_q;
  logic [WORD_W-1:0] d1_n;

  // rising edge n: request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= wr_sel_i;
  end

  // falling edge n: write address
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aval_n <= 1'b0;
      addr_n <= '0;
    end else begin
      aval_n <= req_q;
      if (req_q) addr_n <= addr_i;
    end
  end

  // rising edge n+1: first beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      paddr_q <= '0;
      d0_q    <= '0;
    end else begin
      pend_q <= aval_n;
      if (aval_n) begin
        paddr_q <= addr_n;
        d0_q    <= wr_data_i;
      end
    end
  end

  // falling edge n+1: second beat
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     d1_n <= '0;
    else if (pend_q) d1_n <= wr_data_i;
  end

  assign commit_o      = pend_q;
  assign commit_addr_o = paddr_q;
  assign commit_data_o = {d1_n, d0_q};

  a_r2_addr_to_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aval_n |=> pend_q && (paddr_q == $past(addr_n)));
endmodule

// File: rtl/dpb_array.sv
module dpb_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 18,
  localparam int unsigned PAIR_W = 2 * WORD_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] commit_addr_i,
  input  logic [PAIR_W-1:0] commit_data_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [PAIR_W-1:0] rd_pair_o
);
  logic [PAIR_W-1:0] mem_q [DEPTH];
  logic [PAIR_W-1:0] rd_pair_q;
  logic              fwd_hit;

  always_ff @(posedge clk_i) begin
    if (commit_i) mem_q[commit_addr_i] <= commit_data_i;
  end

  // burst complete but not yet stored: serve from write path
  assign fwd_hit = commit_i && (commit_addr_i == rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_pair_q <= '0;
    else if (!rd_req_i) rd_pair_q <= '0;
    else if (fwd_hit)  rd_pair_q <= commit_data_i;
    else               rd_pair_q <= mem_q[rd_addr_i];
  end

  assign rd_pair_o = rd_pair_q;

  a_r2_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> mem_q[$past(commit_addr_i)] == $past(commit_data_i));

  a_r4_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && commit_i && (rd_addr_i == commit_addr_i)
      |=> rd_pair_q == mem_q[$past(rd_addr_i)]);
endmodule

// File: rtl/dpb_rd_launch.sv
module dpb_rd_launch #(
  parameter int unsigned WORD_W = 18,
  localparam int unsigned PAIR_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAIR_W-1:0] pair_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] lo_n;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_n <= '0;
    else         lo_n <= pair_i[PAIR_W-1:WORD_W];
  end

  // double-rate output: first beat in high phase, second in low phase
  assign rd_data_o = clk_i ? pair_i[WORD_W-1:0] : lo_n;

  a_r1_second_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_n == pair_i[PAIR_W-1:WORD_W]);
endmodule

// File: rtl/dpb_sram.sv
module dpb_sram
  import dpb_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned PAIR_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_sel_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic              rq_v_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [PAIR_W-1:0] commit_data;
  logic [PAIR_W-1:0] rd_pair;

  // read request input register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_v_q    <= 1'b0;
      rq_addr_q <= '0;
    end else begin
      rq_v_q <= rd_sel_i;
      if (rd_sel_i) rq_addr_q <= addr_i;
    end
  end

  dpb_wr_capture #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_sel_i     (wr_sel_i),
    .addr_i       (addr_i),
    .wr_data_i    (wr_data_i),
    .commit_o     (commit),
    .commit_addr_o(commit_addr),
    .commit_data_o(commit_data)
  );

  dpb_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .commit_addr_i(commit_addr),
    .commit_data_i(commit_data),
    .rd_req_i     (rq_v_q),
    .rd_addr_i    (rq_addr_q),
    .rd_pair_o    (rd_pair)
  );

  dpb_rd_launch #(.WORD_W(WORD_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pair_i   (rd_pair),
    .rd_data_o(rd_data_o)
  );

  a_r6_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sel_i |=> ##1 !commit);

  a_r2_request_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_i |=> ##1 commit);

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_i |=> ##1 (rd_pair == '0));

  always_comb begin
    if (!rst_ni) a_r8_reset_idle: assert (rd_data_o == '0 && !commit);
  end
endmodule

// File: tb/dpb_sram_tb_top.sv
module dpb_sram_tb_top;
  localparam int AW = 3;
  localparam int WW = 18;
  localparam int N  = 1 << AW;
  localparam int CLK_PERIOD = 20;
  localparam int Q = CLK_PERIOD / 4;
  localparam logic [WW-1:0] JUNK = 18'h2AAAA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_sel = 1'b0;
  logic          wr_sel = 1'b0;
  logic [WW-1:0] wr_data = '0;
  logic [WW-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [2*WW-1:0] mdl [N];
  logic [2*WW-1:0] exp_pair = '0;
  bit              pend_v = 0;
  logic [WW-1:0]   pend_d0 = '0;
  logic [WW-1:0]   pend_d1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpb_sram #(.ADDR_W(AW), .WORD_W(WW)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .rd_sel_i (rd_sel),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data)
  );

  function automatic logic [2*WW-1:0] pat(input int a, input int s);
    logic [WW-1:0] lo, hi;
    lo = WW'((a * 37 + s * 1031 + 5) & 32'h3FFFF);
    hi = WW'((a * 4099 + s * 77 + 32'h20000) & 32'h3FFFF);
    return {hi, lo};
  endfunction

  task automatic check(input string tag, input string ph, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s phase: actual=%h expected=%h", tag, ph, act, exp);
    end
  endtask

  // entered in the low phase a quarter period before a rising edge
  task automatic step(input string tag, input bit rd_en, input int ra,
                      input bit wr_en, input int wa, input logic [2*WW-1:0] wd);
    logic [2*WW-1:0] nexp;
    rd_sel  = rd_en;
    wr_sel  = wr_en;
    addr    = AW'(ra);
    wr_data = pend_v ? pend_d0 : JUNK;
    nexp    = rd_en ? mdl[ra] : '0;
    @(posedge clk);
    #Q;
    check(tag, "high", rd_data, exp_pair[WW-1:0]);
    addr    = AW'(wa);
    wr_data = pend_v ? pend_d1 : ~JUNK;
    #(2*Q);
    check(tag, "low", rd_data, exp_pair[2*WW-1:WW]);
    exp_pair = nexp;
    if (wr_en) mdl[wa] = wd;
    pend_v  = wr_en;
    pend_d0 = wd[WW-1:0];
    pend_d1 = wd[2*WW-1:WW];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #Q;
    // R8: reset state in both phases
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #Q;
      check("R8", "high", rd_data, '0);
      #(2*Q);
      check("R8", "low", rd_data, '0);
    end
    rst_n = 1'b1;
    // R2: fill every location
    for (int a = 0; a < N; a++) step("R2", 0, 0, 1, a, pat(a, 1));
    step("R7", 0, 0, 0, 0, '0);
    step("R7", 0, 5, 0, 0, '0);
    // R1: read back every location, burst order
    for (int a = 0; a < N; a++) step("R1", 1, a, 0, 0, '0);
    // R3: concurrent read and write, different addresses
    for (int a = 0; a < N; a++) step("R3", 1, a, 1, (a + 3) % N, pat(a, 2));
    step("R3", 1, 1, 0, 0, '0);
    for (int a = 0; a < N; a++) step("R3", 1, (a + 5) % N, 0, 0, '0);
    // R4: read right after write to the same address
    for (int a = 0; a < N; a++) begin
      step("R4", 0, 0, 1, a, pat(a, 3));
      step("R4", 1, a, 0, 0, '0);
    end
    // R4: back-to-back write stream with trailing reads
    for (int a = 0; a < N; a++) step("R4", a > 0, (a + N - 1) % N, 1, a, pat(a, 4));
    step("R4", 1, N - 1, 0, 0, '0);
    // R5: read and write same address, same cycle
    for (int a = 0; a < N; a++) begin
      step("R5", 1, a, 1, a, pat(a, 5));
      step("R5", 0, 0, 0, 0, '0);
      step("R5", 1, a, 0, 0, '0);
    end
    // R6: write port deselected with active bus traffic
    for (int a = 0; a < N; a++) step("R6", 0, a, 0, (a + 2) % N, '0);
    for (int a = 0; a < N; a++) step("R6", 1, a, 0, a, '0);
    // R7: read port deselected while addresses sweep
    for (int a = 0; a < N; a++) step("R7", 0, a, 0, 0, '0);
    step("R7", 1, 2, 0, 0, '0);
    step("R7", 0, 2, 0, 0, '0);
    step("R7", 0, 0, 0, 0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule